// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash model. It watches single-cycle bus writes, each with an address and a data byte. It recognises the keyed multi-write sequences that start programming, whole-chip erase, sector erase, identifier readout and reset. Each recognised command becomes a one-cycle request to an embedded-algorithm engine. The request carries an operation code, the address and the data of the final write.

The block also tracks the device mode: read-array, identifier, programming, erasing or erase-suspended. From that mode it selects what a read returns: array data, an identifier code or a status word. The engine reports its activity on a single busy line. The block uses that line to decide when an operation has finished, when further sector selections may still be queued, and when a suspend can be honoured. A programmable gap, counted after every resume, keeps the erase from being suspended again at once.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the mode is read-array (mode code 0) and no request is raised. A read returns `arr_rdata` in word mode, and `{8'h00, arr_rdata[7:0]}` in byte mode.
- R2: Only the low 12 bits of the write address are compared with the unlock keys. The first unlock address is 555H in word mode and AAAH in byte mode; the second is 2AAH in word mode and 555H in byte mode. The key data are AAH at the first address, then 55H at the second.
- R3: After the two unlock writes, A0H at the first unlock address arms programming. The next write of any value is the program data, even F0H. One cycle after that write, `req_valid` pulses with op code 1 and that write's address and data, and the mode becomes programming (code 2). A request only ever follows a bus write in the cycle before.
- R4: Chip erase is six writes: unlock, 80H at the first unlock address, unlock again, then 10H at the first unlock address. It raises op code 2 and mode erasing (code 3).
- R5: Sector erase is the same six writes ending with 30H at any address. It raises op code 3 with that address. While the engine has not yet gone busy, each further 30H write raises another op 3 request. After a chip erase, or once busy has been seen, 30H writes are ignored.
- R6: In read-array or identifier mode, an F0H write that is not program data raises op code 7 (reset) and leaves the mode at read-array.
- R7: A wrong address or data value at any step of a sequence drops the partial sequence. No request is raised, and the mode returns to read-array, from identifier mode as well.
- R8: Unlock then 90H at the first unlock address raises op code 6 and enters identifier mode (code 1). The offset is `rd_addr[1:0]` in word mode and `rd_addr[2:1]` in byte mode. Offset 0 reads 00C2H. Offset 1 reads 22DAH in word mode and 00DAH in byte mode. Other offsets read 0000H.
- R9: In programming or erasing mode, writes raise no request, with two exceptions. A B0H write while the engine is busy in erasing mode raises op code 4 (suspend) and enters mode code 4. The R5 queue is the other exception. The mode returns to read-array on the first cycle busy is low after busy has been seen high.
- R10: In erase-suspended mode, a 30H write at any address raises op code 5 (resume) and returns to erasing mode. All other writes are ignored.
- R11: Once a resume is accepted, a B0H write presented in the following `resume_gap` cycles is ignored. From the next cycle on it is accepted.
- R12: Reads return array data in read-array and erase-suspended modes. In programming mode they return only bit 7 set to the complement of the programmed data's bit 7. In erasing mode they return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects byte addressing, 0 word addressing |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Read address |
| arr_rdata | input | 16 | Data from the array for `rd_addr` |
| rd_data | output | 16 | Read result selected by mode |
| eng_busy | input | 1 | Embedded-algorithm engine busy |
| resume_gap | input | GAP_W | Cycles after a resume during which suspend is refused |
| req_valid | output | 1 | One-cycle request pulse to the engine |
| req_op | output | 3 | Request operation code (0 when idle) |
| req_addr | output | ADDR_W | Address of the write that raised the request |
| req_data | output | 8 | Data of the write that raised the request |
| mode | output | 3 | Device mode code |

## Verification
Every request and every mode change is registered, so each one is due at the first rising edge after the write or busy change that causes it. `rd_data` is combinational from the registered mode and the present read address, so it follows the same edge. The bench keeps a behavioural model built on a queue of pending writes and a cycle count since the last resume. It settles the expected state before each edge and compares every output 1 ns after the edge, never at it. The gap checks put the B0H write one cycle before and one cycle after the edge where suspend becomes allowed.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;
  typedef enum logic [2:0] {
    MD_READ  = 3'd0,
    MD_IDENT = 3'd1,
    MD_PROG  = 3'd2,
    MD_ERASE = 3'd3,
    MD_SUSP  = 3'd4
  } fmode_t;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_CHIP   = 3'd2,
    OP_SECT   = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5,
    OP_IDENT  = 3'd6,
    OP_RESET  = 3'd7
  } fop_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_DATA, ST_E1, ST_E2, ST_E3
  } step_t;

  localparam logic [7:0] KEY_A     = 8'hAA;
  localparam logic [7:0] KEY_B     = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_RST   = 8'hF0;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
endpackage

// File: rtl/fcd_seq.sv
`timescale 1ns/1ps
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              byte_mode,
  output logic              hit_prog,
  output logic              hit_chip,
  output logic              hit_sect,
  output logic              hit_ident,
  output logic              hit_reset,
  output logic              abort
);
  localparam int KEY_W = 12;

  step_t             step_q, step_d;
  logic [KEY_W-1:0]  key_addr, ua1, ua2;
  logic              at_ua1, at_ua2, act;

  assign key_addr = wr_addr[KEY_W-1:0];
  assign ua1      = byte_mode ? 12'hAAA : 12'h555;
  assign ua2      = byte_mode ? 12'h555 : 12'h2AA;
  assign at_ua1   = (key_addr == ua1);
  assign at_ua2   = (key_addr == ua2);
  assign act      = en & wr_en;

  always_comb begin
    step_d    = step_q;
    hit_prog  = 1'b0;
    hit_chip  = 1'b0;
    hit_sect  = 1'b0;
    hit_ident = 1'b0;
    hit_reset = 1'b0;
    abort     = 1'b0;
    if (act) begin
      step_d = ST_IDLE;
      if (step_q != ST_DATA && wr_data == CMD_RST) begin
        hit_reset = 1'b1;
      end else begin
        unique case (step_q)
          ST_IDLE: if (at_ua1 && wr_data == KEY_A) step_d = ST_U1; else abort = 1'b1;
          ST_U1:   if (at_ua2 && wr_data == KEY_B) step_d = ST_U2; else abort = 1'b1;
          ST_U2: begin
            if (at_ua1 && wr_data == CMD_PROG)       step_d = ST_DATA;
            else if (at_ua1 && wr_data == CMD_ERASE) step_d = ST_E1;
            else if (at_ua1 && wr_data == CMD_IDENT) hit_ident = 1'b1;
            else                                     abort = 1'b1;
          end
          ST_DATA: hit_prog = 1'b1;
          ST_E1:   if (at_ua1 && wr_data == KEY_A) step_d = ST_E2; else abort = 1'b1;
          ST_E2:   if (at_ua2 && wr_data == KEY_B) step_d = ST_E3; else abort = 1'b1;
          ST_E3: begin
            if (at_ua1 && wr_data == CMD_CHIP) hit_chip = 1'b1;
            else if (wr_data == CMD_SECT)      hit_sect = 1'b1;
            else                               abort = 1'b1;
          end
          default: abort = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   step_q <= ST_IDLE;
    else if (act) step_q <= step_d;
  end
endmodule

// File: rtl/fcd_ctrl.sv
`timescale 1ns/1ps
module fcd_ctrl
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int GAP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              eng_busy,
  input  logic [GAP_W-1:0]  resume_gap,
  input  logic              hit_prog,
  input  logic              hit_chip,
  input  logic              hit_sect,
  input  logic              hit_ident,
  input  logic              hit_reset,
  input  logic              abort,
  output logic              seq_en,
  output fmode_t            mode_q,
  output logic              req_valid,
  output fop_t              req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data
);
  fmode_t           mode_d;
  fop_t             op_d;
  logic             seen_q, seen_d, win_q, win_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  assign seq_en = (mode_q == MD_READ) || (mode_q == MD_IDENT);

  always_comb begin
    mode_d = mode_q;
    op_d   = OP_NONE;
    seen_d = seen_q | eng_busy;
    win_d  = win_q & ~eng_busy;
    gap_d  = (gap_q != '0) ? gap_q - 1'b1 : gap_q;
    unique case (mode_q)
      MD_READ, MD_IDENT: begin
        if (hit_reset) begin
          op_d = OP_RESET; mode_d = MD_READ;
        end else if (abort) begin
          mode_d = MD_READ;
        end else if (hit_ident) begin
          op_d = OP_IDENT; mode_d = MD_IDENT;
        end else if (hit_prog) begin
          op_d = OP_PROG; mode_d = MD_PROG; seen_d = 1'b0;
        end else if (hit_chip) begin
          op_d = OP_CHIP; mode_d = MD_ERASE; seen_d = 1'b0; win_d = 1'b0;
        end else if (hit_sect) begin
          op_d = OP_SECT; mode_d = MD_ERASE; seen_d = 1'b0; win_d = 1'b1;
        end
      end
      MD_PROG: if (seen_q && !eng_busy) mode_d = MD_READ;
      MD_ERASE: begin
        if (seen_q && !eng_busy) begin
          mode_d = MD_READ;
        end else if (wr_en && eng_busy && wr_data == CMD_SUSP && gap_q == '0) begin
          op_d = OP_SUSP; mode_d = MD_SUSP; win_d = 1'b0;
        end else if (wr_en && win_q && !eng_busy && wr_data == CMD_SECT) begin
          op_d = OP_SECT;
        end
      end
      MD_SUSP: begin
        if (wr_en && wr_data == CMD_SECT) begin
          op_d = OP_RESUME; mode_d = MD_ERASE; seen_d = 1'b0; win_d = 1'b0;
          gap_d = resume_gap;
        end
      end
      default: mode_d = MD_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_READ;
      seen_q    <= 1'b0;
      win_q     <= 1'b0;
      gap_q     <= '0;
      req_valid <= 1'b0;
      req_op    <= OP_NONE;
    end else begin
      mode_q    <= mode_d;
      seen_q    <= seen_d;
      win_q     <= win_d;
      gap_q     <= gap_d;
      req_valid <= (op_d != OP_NONE);
      req_op    <= op_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr <= '0;
      req_data <= '0;
    end else if (op_d != OP_NONE) begin
      req_addr <= wr_addr;
      req_data <= wr_data;
    end
  end
endmodule

// File: rtl/fcd_rdmux.sv
`timescale 1ns/1ps
module fcd_rdmux
  import fcd_pkg::*;
#(
  parameter logic [7:0]  MFG_ID = 8'hC2,
  parameter logic [15:0] DEV_ID = 16'h22DA
) (
  input  fmode_t      mode,
  input  logic        byte_mode,
  input  logic [2:0]  rd_lo,
  input  logic [15:0] arr_rdata,
  input  logic        prog_b7,
  output logic [15:0] rd_data
);
  logic [1:0]  id_off;
  logic [15:0] id_word;

  assign id_off = byte_mode ? rd_lo[2:1] : rd_lo[1:0];

  always_comb begin
    unique case (id_off)
      2'd0:    id_word = {8'h00, MFG_ID};
      2'd1:    id_word = byte_mode ? {8'h00, DEV_ID[7:0]} : DEV_ID;
      default: id_word = 16'h0000;
    endcase
  end

  always_comb begin
    unique case (mode)
      MD_IDENT: rd_data = id_word;
      MD_PROG:  rd_data = {8'h00, ~prog_b7, 7'b0};
      MD_ERASE: rd_data = 16'h0000;
      default:  rd_data = byte_mode ? {8'h00, arr_rdata[7:0]} : arr_rdata;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int          ADDR_W = 20,
  parameter int          GAP_W  = 12,
  parameter logic [7:0]  MFG_ID = 8'hC2,
  parameter logic [15:0] DEV_ID = 16'h22DA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [15:0]       arr_rdata,
  output logic [15:0]       rd_data,
  input  logic              eng_busy,
  input  logic [GAP_W-1:0]  resume_gap,
  output logic              req_valid,
  output logic [2:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  output logic [2:0]        mode
);
  logic   seq_en, hit_prog, hit_chip, hit_sect, hit_ident, hit_reset, abort;
  fmode_t mode_q;
  fop_t   op_q;

  fcd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(seq_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .byte_mode(byte_mode), .hit_prog(hit_prog),
    .hit_chip(hit_chip), .hit_sect(hit_sect), .hit_ident(hit_ident),
    .hit_reset(hit_reset), .abort(abort)
  );

  fcd_ctrl #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .resume_gap(resume_gap), .hit_prog(hit_prog),
    .hit_chip(hit_chip), .hit_sect(hit_sect), .hit_ident(hit_ident),
    .hit_reset(hit_reset), .abort(abort), .seq_en(seq_en), .mode_q(mode_q),
    .req_valid(req_valid), .req_op(op_q), .req_addr(req_addr), .req_data(req_data)
  );

  fcd_rdmux #(.MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_rdmux (
    .mode(mode_q), .byte_mode(byte_mode), .rd_lo(rd_addr[2:0]),
    .arr_rdata(arr_rdata), .prog_b7(req_data[7]), .rd_data(rd_data)
  );

  assign req_op = op_q;
  assign mode   = mode_q;
endmodule

// File: rtl/fcd_checker.sv
`timescale 1ns/1ps
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [2:0] mode,
  input logic       req_valid,
  input logic [2:0] req_op
);
  AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(wr_en)); // R3

  AST_PROG_ENTERS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1) |-> mode == 3'd2); // R3

  AST_RESET_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd7) |-> mode == 3'd0); // R6

  AST_PROG_IGNORES_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && wr_en) |=> !req_valid); // R9

  AST_SUSP_FROM_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |-> $past(mode) == 3'd3); // R9

  AST_RESUME_TO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && wr_en && wr_data == 8'h30) |=>
      (mode == 3'd3 && req_valid && req_op == 3'd5)); // R10
endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .mode(mode), .req_valid(req_valid), .req_op(req_op)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  localparam int AW = 20;
  localparam int GW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          b_byte = 1'b0, b_wr = 1'b0, b_busy = 1'b0;
  logic [AW-1:0] b_addr = '0, b_rd = '0;
  logic [7:0]    b_data = '0;
  logic [15:0]   b_arr = 16'hA55A;
  logic [GW-1:0] b_gap = 12'd4;
  logic [15:0]   rd_data;
  logic          req_valid;
  logic [2:0]    req_op, mode;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .GAP_W(GW)) i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .byte_mode(b_byte), .wr_en(b_wr), .wr_addr(b_addr),
    .wr_data(b_data), .rd_addr(b_rd), .arr_rdata(b_arr), .rd_data(rd_data),
    .eng_busy(b_busy), .resume_gap(b_gap), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .mode(mode)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural reference state
  int          m_mode = 0, m_since = 1 << 20;
  bit          m_seen = 0, m_win = 0;
  bit          e_valid = 0;
  int          e_op = 0;
  logic [AW-1:0] e_addr = '0;
  logic [7:0]  e_data = '0, m_pdata = '0;
  logic [11:0] hq_a[$];
  logic [7:0]  hq_d[$];

  function automatic int classify(logic bm);
    int n = hq_d.size();
    logic [11:0] u1 = bm ? 12'hAAA : 12'h555;
    logic [11:0] u2 = bm ? 12'h555 : 12'h2AA;
    if (!(hq_a[0] == u1 && hq_d[0] == 8'hAA)) return 0;
    if (n == 1) return 1;
    if (!(hq_a[1] == u2 && hq_d[1] == 8'h55)) return 0;
    if (n == 2) return 1;
    if (hq_a[2] != u1) return 0;
    if (hq_d[2] == 8'h90) return 5;
    if (hq_d[2] == 8'hA0) return (n == 3) ? 1 : 2;
    if (hq_d[2] != 8'h80) return 0;
    if (n == 3) return 1;
    if (!(hq_a[3] == u1 && hq_d[3] == 8'hAA)) return 0;
    if (n == 4) return 1;
    if (!(hq_a[4] == u2 && hq_d[4] == 8'h55)) return 0;
    if (n == 5) return 1;
    if (hq_d[5] == 8'h30) return 4;
    if (hq_d[5] == 8'h10 && hq_a[5] == u1) return 3;
    return 0;
  endfunction

  function automatic logic [15:0] exp_read();
    int off = b_byte ? int'(b_rd[2:1]) : int'(b_rd[1:0]);
    case (m_mode)
      1: return (off == 0) ? 16'h00C2 : (off == 1) ? (b_byte ? 16'h00DA : 16'h22DA) : 16'h0000;
      2: return {8'h00, ~m_pdata[7], 7'b0};
      3: return 16'h0000;
      default: return b_byte ? {8'h00, b_arr[7:0]} : b_arr;
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic issue(int op);
    e_valid = 1; e_op = op; e_addr = b_addr; e_data = b_data;
  endtask

  // one clock: model the edge, then compare after it
  task automatic step();
    int  nm = m_mode;
    bit  ns = m_seen | b_busy;
    bit  nw = m_win & ~b_busy;
    bit  resumed = 0;
    e_valid = 0; e_op = 0;
    case (m_mode)
      0, 1: if (b_wr) begin
        bit pd = (hq_d.size() == 3 && hq_d[2] == 8'hA0);
        if (b_data == 8'hF0 && !pd) begin
          issue(7); nm = 0; hq_a.delete(); hq_d.delete();
        end else begin
          int c;
          hq_a.push_back(b_addr[11:0]); hq_d.push_back(b_data);
          c = classify(b_byte);
          if (c != 1) begin hq_a.delete(); hq_d.delete(); end
          case (c)
            0: nm = 0;
            2: begin issue(1); nm = 2; ns = 0; m_pdata = b_data; end
            3: begin issue(2); nm = 3; ns = 0; nw = 0; end
            4: begin issue(3); nm = 3; ns = 0; nw = 1; end
            5: begin issue(6); nm = 1; end
            default: ;
          endcase
        end
      end
      2: if (m_seen && !b_busy) nm = 0;
      3: begin
        if (m_seen && !b_busy) nm = 0;
        else if (b_wr && b_busy && b_data == 8'hB0 && m_since >= int'(b_gap)) begin
          issue(4); nm = 4; nw = 0;
        end else if (b_wr && m_win && !b_busy && b_data == 8'h30) issue(3);
      end
      4: if (b_wr && b_data == 8'h30) begin
        issue(5); nm = 3; ns = 0; nw = 0; resumed = 1;
      end
      default: nm = 0;
    endcase
    m_since = resumed ? 0 : m_since + 1;
    @(posedge clk); #1;
    m_mode = nm; m_seen = ns; m_win = nw;
    chk("req_valid", 32'(req_valid), 32'(e_valid));
    chk("req_op", 32'(req_op), 32'(e_op));
    if (e_valid) begin
      chk("req_addr", 32'(req_addr), 32'(e_addr));
      chk("req_data", 32'(req_data), 32'(e_data));
    end
    chk("mode", 32'(mode), 32'(m_mode));
    chk("rd_data", 32'(rd_data), 32'(exp_read()));
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    b_wr = 1; b_addr = a; b_data = d; step(); b_wr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic unlock();
    wr(b_byte ? 20'hAAA : 20'h555, 8'hAA);
    wr(b_byte ? 20'h555 : 20'h2AA, 8'h55);
  endtask

  function automatic logic [AW-1:0] ua1();
    return b_byte ? 20'hAAA : 20'h555;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1"; idle(2);
    b_byte = 1; idle(1); b_byte = 0;

    cur_req = "R3"; // word program, status read during busy (R12)
    unlock(); wr(20'h555, 8'hA0); wr(20'h12345, 8'h3C);
    cur_req = "R12"; idle(1); b_busy = 1; idle(3);
    cur_req = "R9"; wr(20'h555, 8'hAA); wr(20'h123, 8'hF0);
    b_busy = 0; idle(2);

    cur_req = "R2"; // byte program, F0 as data
    b_byte = 1; b_arr = 16'h7E81;
    unlock(); wr(20'hAAA, 8'hA0); wr(20'h0ABCD, 8'hF0);
    b_busy = 1; idle(2); b_busy = 0; idle(2);

    cur_req = "R7"; // word keys in byte mode and bad command
    wr(20'h555, 8'hAA); wr(20'h2AA, 8'h55); idle(1);
    unlock(); wr(20'hAAA, 8'h77); idle(1);
    b_byte = 0; wr(20'h555, 8'hAA); wr(20'h2AA, 8'h56); idle(1);

    cur_req = "R8"; // identifier reads
    unlock(); wr(20'h555, 8'h90);
    for (int i = 0; i < 4; i++) begin b_rd = 20'(i); idle(1); end
    b_byte = 1;
    for (int i = 0; i < 8; i += 2) begin b_rd = 20'(i); idle(1); end
    b_byte = 0; b_rd = '0;
    cur_req = "R6"; wr(20'h7777, 8'hF0); idle(1);
    cur_req = "R7"; unlock(); wr(20'h555, 8'h90); wr(20'h0, 8'h12); idle(1);
    cur_req = "R6"; wr(20'h0, 8'hF0);

    cur_req = "R4"; // chip erase
    unlock(); wr(20'h555, 8'h80); unlock(); wr(20'h555, 8'h10);
    cur_req = "R5"; wr(20'h40000, 8'h30);
    cur_req = "R9"; b_busy = 1; idle(1); wr(20'h555, 8'hAA); wr(20'h0, 8'h30);
    b_busy = 0; idle(2);

    cur_req = "R5"; // sector erase with queued sectors
    unlock(); wr(20'h555, 8'h80); unlock(); wr(20'h40000, 8'h30);
    wr(20'h50000, 8'h30); wr(20'h60000, 8'h30);
    b_busy = 1; idle(1); wr(20'h70000, 8'h30);
    cur_req = "R9"; wr(20'h0, 8'hB0); idle(1);
    cur_req = "R10"; wr(20'h0, 8'hB0); wr(20'h555, 8'hAA); idle(1);
    cur_req = "R12"; b_rd = 20'h3; idle(1);
    cur_req = "R10"; wr(20'h12, 8'h30);
    cur_req = "R11"; wr(20'h0, 8'hB0); idle(2); wr(20'h0, 8'hB0); wr(20'h0, 8'hB0);
    cur_req = "R10"; wr(20'h0, 8'h30);
    cur_req = "R11"; idle(3); wr(20'h0, 8'hB0);
    wr(20'h0, 8'h30); b_busy = 0; idle(1);
    cur_req = "R9"; b_busy = 1; idle(2); b_busy = 0; idle(2);
    cur_req = "R1"; b_arr = 16'h1234; idle(1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule